// File: doc/BRIEF.md
# Asynchronous Serial Receiver with Status Flags

This block recovers asynchronous serial characters from one receive line. A bus-clock counter loaded with a 13-bit divisor makes a sampling tick, and sixteen ticks make one bit time. The line input can come from the pin or, in loop mode, from the local transmitter output, and it can be inverted before any decision is made. A frame carries a start bit, then 8 or 9 payload bits (least significant first), then one stop bit. When parity is enabled the last payload bit is the parity bit.

Each completed frame moves its payload into a read-only buffer: a data byte plus a separate ninth bit. Eight sticky status flags report the events of the receive path. Software clears them with a write-one-to-clear strobe vector. A mask vector selects which flags drive the single interrupt output.

Top module: `serial_rx_unit`

## Requirements
- R1: A sampling tick occurs once every `baud_div` bus clocks and a bit lasts 16 ticks. With `baud_div` equal to 0 no tick occurs and no character is received.
- R2: `nine_bit` = 0 selects 8 payload bits and `nine_bit` = 1 selects 9. The ninth payload bit appears on `rx_bit8`, which reads 0 in 8-bit mode.
- R3: A start bit begins on a high-to-low change between two tick samples. The start bit is confirmed by a majority of ticks 7, 8 and 9 of the bit. A low pulse shorter than half a bit is dropped, and the data buffer is not written.
- R4: The stop bit is decided at its middle. If `rx_status[0]` (full) is clear, the payload is copied to `rx_data`/`rx_bit8` and full is set one clock later.
- R5: Each bit takes the majority of its three centre samples. If the three samples of any bit in a stored frame disagree, `rx_status[3]` (noise) is set.
- R6: A stop bit decided low on a stored frame sets `rx_status[2]` (framing error). The data is still stored.
- R7: A frame that completes while full is set sets `rx_status[1]` (overrun). `rx_data` keeps the older character.
- R8: When `break_det_en` = 1 and all payload bits and the stop bit are 0, `rx_status[6]` (break) is set. Nothing is stored, and neither full nor framing error is set.
- R9: With `parity_en` = 1 the XOR of all payload bits must equal `parity_odd`. A mismatch sets `rx_status[4]` (parity error).
- R10: After a completed frame, once the line has stayed high for one character time (16 × (10 + `nine_bit`) ticks) in a row, `rx_status[5]` (idle) is set.
- R11: A falling edge of the corrected line while `rx_enable` = 1 sets `rx_status[7]` (active edge). No edge is flagged while disabled.
- R12: `rx_invert` = 1 inverts the selected source. `loop_en` = 1 takes the source from `loop_tx`, and `rx_pin` then has no effect.
- R13: After reset all flags and the buffer are 0. A 1 in `flag_clr[i]` clears `rx_status[i]` (a set in the same cycle wins), and `irq` is high when any flag with a 1 in `irq_en` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_enable | input | 1 | Receiver enable |
| baud_div | input | 13 | Bus clocks per sampling tick |
| nine_bit | input | 1 | 9-bit payload select |
| parity_en | input | 1 | Parity check enable |
| parity_odd | input | 1 | 1 = odd parity, 0 = even |
| break_det_en | input | 1 | Break detection enable |
| rx_invert | input | 1 | Invert the selected line source |
| loop_en | input | 1 | Take the line from the transmitter output |
| rx_pin | input | 1 | Serial receive pin |
| loop_tx | input | 1 | Local transmitter output |
| flag_clr | input | 8 | Write-one-to-clear strobes, one per flag |
| irq_en | input | 8 | Interrupt enable, one per flag |
| rx_data | output | 8 | Received data byte |
| rx_bit8 | output | 1 | Received ninth bit |
| rx_status | output | 8 | Flags: 0 full, 1 overrun, 2 framing, 3 noise, 4 parity, 5 idle, 6 break, 7 edge |
| irq | output | 1 | Combined masked interrupt |

## Verification
A frame's data and its full, overrun, framing, noise, parity and break flags change one clock after the tick at the middle of the stop bit. That tick falls at most two sync clocks plus one tick period after the nominal centre. The bench therefore samples two bit times after it has finished driving the stop bit, which is well before any idle flag could appear. The idle flag is due one character time after the stop-bit centre. It is checked once at two bit times, when it must still be low, and once about fourteen bit times later, when it must be set. The edge flag rises one clock after the synchronised falling edge and is read at the same point as the frame results.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int OVS        = 16;
  localparam int PHASE_W    = 4;
  localparam int MAX_PAY    = 9;
  localparam int IDX_W      = 4;
  localparam int MAX_TICKS  = OVS * (MAX_PAY + 2);
  localparam int IDLE_W     = $clog2(MAX_TICKS + 1);
  localparam int NUM_FLAGS  = 8;

  localparam int FLG_FULL   = 0;
  localparam int FLG_OVR    = 1;
  localparam int FLG_FRAME  = 2;
  localparam int FLG_NOISE  = 3;
  localparam int FLG_PAR    = 4;
  localparam int FLG_IDLE   = 5;
  localparam int FLG_BREAK  = 6;
  localparam int FLG_EDGE   = 7;

  typedef enum logic [0:0] {ST_HUNT, ST_FRAME} srx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic split3(input logic a, input logic b, input logic c);
    return (a != b) || (b != c);
  endfunction

  function automatic logic [IDX_W-1:0] pay_bits(input logic nine);
    return nine ? IDX_W'(9) : IDX_W'(8);
  endfunction

  function automatic logic [IDLE_W-1:0] idle_last(input logic nine);
    return IDLE_W'(OVS * (10 + (nine ? 1 : 0)) - 1);
  endfunction

  function automatic logic parity_bad(input logic [MAX_PAY-1:0] pay, input logic odd);
    return (^pay) != odd;
  endfunction
endpackage

// File: rtl/srx_baud_gen.sv
module srx_baud_gen #(
  parameter int DIV_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] cnt;
  logic             div_live;

  assign div_live = (div != '0);
  assign tick     = en && div_live && (cnt >= div - DIV_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !div_live || tick) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + DIV_W'(1);
    end
  end
endmodule

// File: rtl/srx_line_front.sv
module srx_line_front (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic rx_pin,
  input  logic loop_tx,
  input  logic loop_en,
  input  logic invert,
  output logic line,
  output logic edge_evt
);
  logic [1:0] sync_q;
  logic       prev_q;
  logic       src;

  assign src      = loop_en ? loop_tx : rx_pin;
  assign line     = sync_q[1] ^ invert;
  assign edge_evt = en && prev_q && !line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], src};
      prev_q <= line;
    end
  end
endmodule

// File: rtl/srx_frame_engine.sv
module srx_frame_engine
  import srx_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               tick,
  input  logic               line,
  input  logic               nine_bit,
  input  logic               parity_en,
  input  logic               parity_odd,
  input  logic               brk_en,
  input  logic               buf_full,
  output logic               store_evt,
  output logic               overrun_evt,
  output logic               break_evt,
  output logic               frame_err_evt,
  output logic               noise_evt,
  output logic               parity_evt,
  output logic               idle_evt,
  output logic [MAX_PAY-1:0] cap_data
);
  srx_state_e         state;
  logic [PHASE_W-1:0] phase;
  logic [IDX_W-1:0]   bit_idx;
  logic [IDX_W-1:0]   pay_idx;
  logic [MAX_PAY-1:0] payload;
  logic               s7, s8, noisy, last_s;
  logic               idle_armed;
  logic [IDLE_W-1:0]  idle_cnt;

  logic active, at_mid, bit_val, bit_noise, is_start, is_stop;
  logic start_seen, finish, zero_frame, idle_hit;

  assign active    = en && tick;
  assign at_mid    = (state == ST_FRAME) && (phase == PHASE_W'(9));
  assign bit_val   = maj3(s7, s8, line);
  assign bit_noise = split3(s7, s8, line);
  assign is_start  = (bit_idx == '0);
  assign is_stop   = (bit_idx == pay_bits(nine_bit) + IDX_W'(1));
  assign pay_idx   = bit_idx - IDX_W'(1);
  assign start_seen = (state == ST_HUNT) && last_s && !line;
  assign finish    = active && at_mid && is_stop;

  assign cap_data   = nine_bit ? payload : {1'b0, payload[MAX_PAY-2:0]};
  assign zero_frame = (cap_data == '0) && !bit_val;

  assign break_evt     = finish && brk_en && zero_frame;
  assign overrun_evt   = finish && !break_evt && buf_full;
  assign store_evt     = finish && !break_evt && !buf_full;
  assign frame_err_evt = store_evt && !bit_val;
  assign noise_evt     = store_evt && (noisy || bit_noise);
  assign parity_evt    = store_evt && parity_en && parity_bad(cap_data, parity_odd);

  assign idle_hit = (idle_cnt >= idle_last(nine_bit));
  assign idle_evt = active && (state == ST_HUNT) && idle_armed && line && idle_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_HUNT;
      phase      <= '0;
      bit_idx    <= '0;
      payload    <= '0;
      s7         <= 1'b1;
      s8         <= 1'b1;
      noisy      <= 1'b0;
      last_s     <= 1'b0;
      idle_armed <= 1'b0;
      idle_cnt   <= '0;
    end else if (!en) begin
      state      <= ST_HUNT;
      last_s     <= 1'b0;
      idle_armed <= 1'b0;
      idle_cnt   <= '0;
    end else if (tick) begin
      case (state)
        ST_HUNT: begin
          last_s <= line;
          if (idle_armed) begin
            if (!line) begin
              idle_cnt <= '0;
            end else if (idle_hit) begin
              idle_armed <= 1'b0;
              idle_cnt   <= '0;
            end else begin
              idle_cnt <= idle_cnt + IDLE_W'(1);
            end
          end
          if (start_seen) begin
            state    <= ST_FRAME;
            phase    <= PHASE_W'(1);
            bit_idx  <= '0;
            noisy    <= 1'b0;
            idle_cnt <= '0;
          end
        end
        ST_FRAME: begin
          if (phase == PHASE_W'(7)) s7 <= line;
          if (phase == PHASE_W'(8)) s8 <= line;
          if (at_mid) begin
            if (is_start) begin
              if (bit_val) begin
                state  <= ST_HUNT;
                last_s <= 1'b1;
              end else begin
                noisy <= noisy | bit_noise;
              end
            end else if (is_stop) begin
              state      <= ST_HUNT;
              last_s     <= bit_val;
              idle_armed <= 1'b1;
              idle_cnt   <= '0;
            end else begin
              payload[pay_idx] <= bit_val;
              noisy            <= noisy | bit_noise;
            end
          end
          if (phase == PHASE_W'(OVS - 1)) begin
            phase   <= '0;
            bit_idx <= bit_idx + IDX_W'(1);
          end else begin
            phase <= phase + PHASE_W'(1);
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/srx_status_flags.sv
module srx_status_flags #(
  parameter int NF    = 8,
  parameter int PAY_W = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NF-1:0]    set_vec,
  input  logic [NF-1:0]    clr_vec,
  input  logic             store,
  input  logic [PAY_W-1:0] cap_data,
  output logic [NF-1:0]    flags,
  output logic [PAY_W-2:0] data_q,
  output logic             bit8_q
);
  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          flags[i] <= 1'b0;
      else if (set_vec[i]) flags[i] <= 1'b1;
      else if (clr_vec[i]) flags[i] <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
      bit8_q <= 1'b0;
    end else if (store) begin
      data_q <= cap_data[PAY_W-2:0];
      bit8_q <= cap_data[PAY_W-1];
    end
  end
endmodule

// File: rtl/serial_rx_unit.sv
module serial_rx_unit
  import srx_pkg::*;
#(
  parameter int DIV_W = 13
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_enable,
  input  logic [DIV_W-1:0]     baud_div,
  input  logic                 nine_bit,
  input  logic                 parity_en,
  input  logic                 parity_odd,
  input  logic                 break_det_en,
  input  logic                 rx_invert,
  input  logic                 loop_en,
  input  logic                 rx_pin,
  input  logic                 loop_tx,
  input  logic [NUM_FLAGS-1:0] flag_clr,
  input  logic [NUM_FLAGS-1:0] irq_en,
  output logic [7:0]           rx_data,
  output logic                 rx_bit8,
  output logic [NUM_FLAGS-1:0] rx_status,
  output logic                 irq
);
  logic tick, line, edge_evt;
  logic store_evt, overrun_evt, break_evt, frame_err_evt;
  logic noise_evt, parity_evt, idle_evt;
  logic [MAX_PAY-1:0]   cap_data;
  logic [NUM_FLAGS-1:0] set_vec;

  srx_baud_gen #(.DIV_W(DIV_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .div(baud_div), .tick(tick)
  );

  srx_line_front u_front (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .rx_pin(rx_pin),
    .loop_tx(loop_tx), .loop_en(loop_en), .invert(rx_invert),
    .line(line), .edge_evt(edge_evt)
  );

  srx_frame_engine u_engine (
    .clk(clk), .rst_n(rst_n), .en(rx_enable), .tick(tick), .line(line),
    .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .brk_en(break_det_en), .buf_full(rx_status[FLG_FULL]),
    .store_evt(store_evt), .overrun_evt(overrun_evt), .break_evt(break_evt),
    .frame_err_evt(frame_err_evt), .noise_evt(noise_evt),
    .parity_evt(parity_evt), .idle_evt(idle_evt), .cap_data(cap_data)
  );

  always_comb begin
    set_vec            = '0;
    set_vec[FLG_FULL]  = store_evt;
    set_vec[FLG_OVR]   = overrun_evt;
    set_vec[FLG_FRAME] = frame_err_evt;
    set_vec[FLG_NOISE] = noise_evt;
    set_vec[FLG_PAR]   = parity_evt;
    set_vec[FLG_IDLE]  = idle_evt;
    set_vec[FLG_BREAK] = break_evt;
    set_vec[FLG_EDGE]  = edge_evt;
  end

  srx_status_flags #(.NF(NUM_FLAGS), .PAY_W(MAX_PAY)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(flag_clr),
    .store(store_evt), .cap_data(cap_data), .flags(rx_status),
    .data_q(rx_data), .bit8_q(rx_bit8)
  );

  assign irq = |(rx_status & irq_en);
endmodule

// File: rtl/serial_rx_unit_sva.sv
module srx_checker #(
  parameter int DIV_W = 13
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rx_enable,
  input logic [DIV_W-1:0] baud_div,
  input logic             tick,
  input logic             line,
  input logic             store_evt,
  input logic             overrun_evt,
  input logic             break_evt,
  input logic             edge_evt,
  input logic             idle_evt,
  input logic [7:0]       rx_data,
  input logic [7:0]       rx_status
);
  AST_TICK_NEEDS_DIV: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> (baud_div != '0));  // R1
  AST_FULL_AFTER_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |=> rx_status[0]);  // R4
  AST_STORE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    store_evt |-> !rx_status[0]);  // R7
  AST_OVERRUN_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    overrun_evt |=> ($stable(rx_data) && rx_status[1]));  // R7
  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({store_evt, overrun_evt, break_evt}));  // R8
  AST_BREAK_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    break_evt |=> (rx_status[6] && !$rose(rx_status[0])));  // R8
  AST_IDLE_ON_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    idle_evt |-> line);  // R10
  AST_EDGE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    edge_evt |=> rx_status[7]);  // R11
  AST_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_enable |-> !(store_evt || overrun_evt || break_evt || edge_evt));  // R11
endmodule

bind serial_rx_unit srx_checker #(.DIV_W(DIV_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .baud_div(baud_div),
  .tick(tick), .line(line), .store_evt(store_evt), .overrun_evt(overrun_evt),
  .break_evt(break_evt), .edge_evt(edge_evt), .idle_evt(idle_evt),
  .rx_data(rx_data), .rx_status(rx_status)
);

// File: tb/tb_serial_rx_unit.sv
`timescale 1ns/1ps
module tb_serial_rx_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_enable, nine_bit, parity_en, parity_odd, break_det_en;
  logic        rx_invert, loop_en, rx_pin, loop_tx;
  logic [12:0] baud_div;
  logic [7:0]  flag_clr, irq_en;
  logic [7:0]  rx_data, rx_status;
  logic        rx_bit8, irq;

  int checks = 0;
  int fails  = 0;
  int cur_div = 4;

  always #2.5 clk = ~clk;

  serial_rx_unit dut (
    .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .baud_div(baud_div),
    .nine_bit(nine_bit), .parity_en(parity_en), .parity_odd(parity_odd),
    .break_det_en(break_det_en), .rx_invert(rx_invert), .loop_en(loop_en),
    .rx_pin(rx_pin), .loop_tx(loop_tx), .flag_clr(flag_clr), .irq_en(irq_en),
    .rx_data(rx_data), .rx_bit8(rx_bit8), .rx_status(rx_status), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic int bit_time();
    return 16 * ((cur_div == 0) ? 4 : cur_div);
  endfunction

  task automatic drv(input logic v);
    if (loop_en) loop_tx = v ^ rx_invert;
    else         rx_pin  = v ^ rx_invert;
  endtask

  task automatic clear_flags(input logic [7:0] m);
    flag_clr = m;
    wait_clk(1);
    flag_clr = 8'h00;
    wait_clk(1);
  endtask

  task automatic cfg(input int div, input logic nine, input logic par, input logic odd,
                     input logic inv, input logic lp, input logic brk);
    rx_enable = 1'b0;
    wait_clk(1);
    cur_div = div; baud_div = 13'(div); nine_bit = nine; parity_en = par;
    parity_odd = odd; rx_invert = inv; loop_en = lp; break_det_en = brk;
    rx_pin = ~inv; loop_tx = ~inv;
    wait_clk(4);
    rx_enable = 1'b1;
    wait_clk(2 * bit_time());
    clear_flags(8'hFF);
  endtask

  task automatic send_frame(input logic [8:0] pay, input logic stop_v, input int glitch);
    int nb;
    int d;
    logic v;
    nb = nine_bit ? 9 : 8;
    d  = (cur_div == 0) ? 4 : cur_div;
    for (int b = 0; b < nb + 2; b++) begin
      if (b == 0)           v = 1'b0;
      else if (b == nb + 1) v = stop_v;
      else                  v = pay[b-1];
      if (b == glitch) begin
        drv(v);  wait_clk(8 * d + 2);
        drv(~v); wait_clk(d);
        drv(v);  wait_clk(7 * d - 2);
      end else begin
        drv(v);  wait_clk(16 * d);
      end
    end
    drv(1'b1);
  endtask

  function automatic logic [8:0] with_parity(input logic [8:0] p, input logic nine,
                                             input logic odd, input logic flip);
    logic [8:0] r;
    int top;
    top = nine ? 8 : 7;
    r = nine ? p : {1'b0, p[7:0]};
    r[top] = 1'b0;
    r[top] = (^r) ^ odd ^ flip;
    return r;
  endfunction

  function automatic logic [7:0] exp_flags(input logic stored, input logic ferr,
                                           input logic perr, input logic noise, input logic brk);
    logic [7:0] f;
    f = 8'h80;
    if (brk) f[6] = 1'b1;
    if (stored) begin
      f[0] = 1'b1; f[2] = ferr; f[4] = perr; f[3] = noise;
    end
    return f;
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 1'b0; rx_enable = 1'b0; baud_div = 13'd4; nine_bit = 1'b0;
    parity_en = 1'b0; parity_odd = 1'b0; break_det_en = 1'b0; rx_invert = 1'b0;
    loop_en = 1'b0; rx_pin = 1'b1; loop_tx = 1'b1; flag_clr = 8'h00; irq_en = 8'h00;
    wait_clk(6);
    rst_n = 1'b1;
    wait_clk(2);
    check("R13 reset status", {8'h00, rx_status}, 16'h0000);
    check("R13 reset data", {7'h0, rx_bit8, rx_data}, 16'h0000);
    check("R13 reset irq", {15'h0, irq}, 16'h0000);

    // R11: no edge while disabled
    rx_pin = 1'b0; wait_clk(20); rx_pin = 1'b1; wait_clk(20);
    check("R11 edge ignored when off", {8'h00, rx_status}, 16'h0000);

    // R4 R2 R10: plain 8-bit frame and idle timing
    cfg(4, 0, 0, 0, 0, 0, 0);
    send_frame(9'h0A5, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R4 data 8-bit", {7'h0, rx_bit8, rx_data}, 16'h00A5);
    check("R4 R11 flags", {8'h00, rx_status}, 16'h0081);
    check("R10 idle not yet", {15'h0, rx_status[5]}, 16'h0000);
    wait_clk(12 * bit_time());
    check("R10 idle after char time", {15'h0, rx_status[5]}, 16'h0001);
    clear_flags(8'h20);
    check("R13 clear only idle", {8'h00, rx_status}, 16'h0081);

    // R13 interrupt masking
    irq_en = 8'h01; wait_clk(1);
    check("R13 irq full", {15'h0, irq}, 16'h0001);
    clear_flags(8'h01);
    check("R13 irq cleared", {7'h0, irq, rx_status}, 16'h0080);
    irq_en = 8'h80; wait_clk(1);
    check("R13 irq edge", {15'h0, irq}, 16'h0001);
    irq_en = 8'h00;

    // R2 nine-bit
    cfg(3, 1, 0, 0, 0, 0, 0);
    send_frame(9'h1C3, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R2 ninth bit", {7'h0, rx_bit8, rx_data}, 16'h01C3);

    // R9 parity even good / odd bad
    cfg(4, 0, 1, 0, 0, 0, 0);
    send_frame(with_parity(9'h035, 0, 0, 0), 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R9 even parity ok", {8'h00, rx_status}, 16'h0081);
    cfg(4, 1, 1, 1, 0, 0, 0);
    send_frame(with_parity(9'h0F0, 1, 1, 1), 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R9 odd parity bad", {8'h00, rx_status}, 16'h0091);

    // R6 framing error
    cfg(4, 0, 0, 0, 0, 0, 1);
    send_frame(9'h03C, 1'b0, -1);
    wait_clk(2 * bit_time());
    check("R6 framing flags", {8'h00, rx_status}, 16'h0085);
    check("R6 data kept", {8'h00, rx_data}, 16'h003C);

    // R8 break with and without detection
    cfg(4, 0, 0, 0, 0, 0, 1);
    send_frame(9'h000, 1'b0, -1);
    wait_clk(2 * bit_time());
    check("R8 break flags", {8'h00, rx_status}, 16'h00C0);
    cfg(4, 0, 0, 0, 0, 0, 0);
    send_frame(9'h000, 1'b0, -1);
    wait_clk(2 * bit_time());
    check("R8 break off gives framing", {8'h00, rx_status}, 16'h0085);

    // R7 overrun
    cfg(4, 0, 0, 0, 0, 0, 0);
    send_frame(9'h011, 1'b1, -1);
    wait_clk(bit_time());
    send_frame(9'h022, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R7 overrun flags", {8'h00, rx_status}, 16'h0083);
    check("R7 old data kept", {8'h00, rx_data}, 16'h0011);

    // R5 noise on one sample of data bit 3
    cfg(4, 0, 0, 0, 0, 0, 0);
    send_frame(9'h06D, 1'b1, 4);
    wait_clk(2 * bit_time());
    check("R5 noise flags", {8'h00, rx_status}, 16'h0089);
    check("R5 majority data", {8'h00, rx_data}, 16'h006D);

    // R3 false start
    cfg(4, 0, 0, 0, 0, 0, 0);
    drv(1'b0); wait_clk(12); drv(1'b1);
    wait_clk(3 * bit_time());
    check("R3 false start flags", {8'h00, rx_status}, 16'h0080);
    check("R3 buffer untouched", {8'h00, rx_data}, 16'h006D);

    // R12 inversion and loop path
    cfg(5, 0, 0, 0, 1, 0, 0);
    send_frame(9'h05A, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R12 inverted data", {8'h00, rx_data}, 16'h005A);
    cfg(2, 0, 0, 0, 0, 1, 0);
    rx_pin = 1'b0;
    send_frame(9'h0E7, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R12 loop data", {8'h00, rx_data}, 16'h00E7);
    check("R12 loop flags", {8'h00, rx_status}, 16'h0081);

    // R1 divisor zero: no reception
    cfg(0, 0, 0, 0, 0, 0, 0);
    send_frame(9'h099, 1'b1, -1);
    wait_clk(2 * bit_time());
    check("R1 no tick no data", {7'h0, rx_status[0], rx_data}, 16'h00E7);

    // Random frames (R1 R2 R4 R6 R8 R9 R12)
    for (int i = 0; i < 24; i++) begin
      logic nine, par, odd, inv, lp, stp, flip, zero, brk;
      logic [8:0] p;
      int dv;
      dv   = 2 + int'($urandom % 4);
      nine = 1'($urandom); par = 1'($urandom); odd = 1'($urandom);
      inv  = 1'($urandom); lp  = 1'($urandom);
      stp  = ($urandom % 8) != 0;
      flip = ($urandom % 4) == 0;
      p    = 9'($urandom);
      if ((i % 8) == 5) p = 9'h000;
      if (!nine) p[8] = 1'b0;
      if (par) p = with_parity(p, nine, odd, flip);
      cfg(dv, nine, par, odd, inv, lp, 1'b1);
      send_frame(p, stp, -1);
      wait_clk(2 * bit_time());
      zero = (p == 9'h000);
      brk  = zero && !stp;
      check("R4 R8 R9 random flags", {8'h00, rx_status},
            {8'h00, exp_flags(!brk, !stp, par && ((^p) != odd), 1'b0, brk)});
      if (!brk)
        check("R2 R12 random data", {7'h0, rx_bit8, rx_data}, {7'h0, p});
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule